// File: doc/BRIEF.md
# Microsecond Tick Divider

This block turns a fast system clock, anywhere from a few megahertz up to about 128 MHz, into a slow timing enable for a one-wire bus master. The enable comes out as a single-cycle pulse, and the host aims to fire it roughly once per microsecond. The host picks a 5-bit divisor code to suit its clock and writes it through a simple write strobe. The block then runs two counters in cascade. The first is an odd pre-divider and the second is a power-of-two prescaler. The tick fires when both counters wrap in the same cycle.

The code packs two fields. Bits [1:0] select an odd factor: 00 selects 1, 01 selects 3, 10 selects 5 and 11 selects 7. Bits [4:2] hold an exponent n, which selects a prescale of 2^n. The tick period in clock cycles is the odd factor times 2^n. For example, code 0x08 divides a 4 MHz clock by 4, and code 0x06 divides a 10 MHz clock by 10. The all-zero code means the block has not been programmed. In that state both counters are held cleared and no tick is produced. Every write restarts both counters, whether or not the code changes. The host is expected to let the tick settle for about a millisecond after it programs the code.

Top module: `usec_tick_div`

## Requirements
- R1: After an asynchronous reset the stored code is 0 and `tick` stays low until a non-zero code is written.
- R2: For a non-zero code the tick period in clock cycles is (2*code[1:0]+1) * 2^code[4:2]. The smallest period is 2 (code 0x04) and the largest is 896 (code 0x1F).
- R3: `tick` is high for exactly one cycle at a time and is never high in two consecutive cycles.
- R4: While the stored code is 0 both counters are held cleared and `tick` never rises.
- R5: A write (`cfg_we` high at a rising edge) clears both counters at that edge. The first tick is then high in cycle number P counted from that edge, where P is the new period. This also holds when the code written is the same as the one already stored.
- R6: Once running, consecutive ticks are exactly P cycles apart for every non-zero code.
- R7: Writing code 0 stops the ticks from the cycle after the write edge onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the divisor code |
| cfg_code | input | 5 | Divisor code: bits [1:0] select the odd factor, bits [4:2] hold the exponent n |
| tick | output | 1 | Single-cycle timing enable |

## Verification
The assertions assume that the code only changes through a write strobe sampled at a clock edge. They also assume that `cfg_code` is defined whenever `cfg_we` is high. Under these assumptions, the one-cycle rule and the "no tick right after a write" rule hold for every code, because the smallest non-zero period is two cycles. The bench changes `cfg_we` and `cfg_code` only on falling edges and drops the strobe after one cycle. It sweeps all 31 non-zero codes, and it also rewrites codes in the middle of a period to test the restart.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;
  localparam int SEL_W   = 2;
  localparam int EXP_W   = 3;
  localparam int CODE_W  = SEL_W + EXP_W;
  localparam int ODD_W   = SEL_W + 1;
  localparam int POW_W   = (1 << EXP_W) - 1;
  localparam int RATIO_W = ODD_W + POW_W;

  typedef logic [CODE_W-1:0] code_t;

  // odd pre-divide factor: 1, 3, 5 or 7
  function automatic logic [ODD_W-1:0] odd_factor(input logic [SEL_W-1:0] sel);
    return {sel, 1'b1};
  endfunction

  // all-ones mask marking the last prescaler count for 2^exp
  function automatic logic [POW_W-1:0] pow_mask(input logic [EXP_W-1:0] exp);
    logic [POW_W:0] one;
    logic [POW_W:0] tmp;
    one = {{POW_W{1'b0}}, 1'b1};
    tmp = (one << exp) - one;
    return tmp[POW_W-1:0];
  endfunction

  // total tick period in clock cycles for a non-zero code
  function automatic logic [RATIO_W-1:0] tick_ratio(input code_t c);
    logic [RATIO_W-1:0] f;
    f = RATIO_W'(odd_factor(c[SEL_W-1:0]));
    return f << c[CODE_W-1:SEL_W];
  endfunction
endpackage

// File: rtl/usec_code_reg.sv
module usec_code_reg
  import usec_tick_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  code_t code_in,
  output code_t code_q,
  output logic  restart,
  output logic  run
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  code_q <= '0;
    else if (we) code_q <= code_in;
  end

  assign restart = we;
  assign run     = (code_q != '0);
endmodule

// File: rtl/usec_odd_stage.sv
module usec_odd_stage
  import usec_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             wrap
);
  logic [ODD_W-1:0] cnt;
  logic [ODD_W-1:0] limit;

  assign limit = odd_factor(sel) - ODD_W'(1);
  assign wrap  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || !run) cnt <= '0;
    else if (wrap)           cnt <= '0;
    else                     cnt <= cnt + ODD_W'(1);
  end
endmodule

// File: rtl/usec_pow_stage.sv
module usec_pow_stage
  import usec_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             advance,
  input  logic [EXP_W-1:0] exp,
  output logic             last
);
  logic [POW_W-1:0] cnt;

  assign last = (cnt == pow_mask(exp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || !run) cnt <= '0;
    else if (advance) begin
      if (last) cnt <= '0;
      else      cnt <= cnt + POW_W'(1);
    end
  end
endmodule

// File: rtl/usec_tick_div.sv
module usec_tick_div
  import usec_tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_code,
  output logic              tick
);
  code_t code_q;
  logic  restart;
  logic  run;
  logic  pre_en;
  logic  pow_last;

  usec_code_reg u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .code_in (cfg_code),
    .code_q  (code_q),
    .restart (restart),
    .run     (run)
  );

  usec_odd_stage u_odd (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .sel     (code_q[SEL_W-1:0]),
    .wrap    (pre_en)
  );

  usec_pow_stage u_pow (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .advance (pre_en),
    .exp     (code_q[CODE_W-1:SEL_W]),
    .last    (pow_last)
  );

  assign tick = pre_en && pow_last;
endmodule

// File: rtl/usec_tick_div_chk.sv
module usec_tick_div_chk
  import usec_tick_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CODE_W-1:0] cfg_code,
  input logic              tick,
  input code_t             code_q,
  input logic              pre_en
);
  logic [RATIO_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap <= '0;
    else if (cfg_we || tick)           gap <= '0;
    else if (gap != {RATIO_W{1'b1}})   gap <= gap + RATIO_W'(1);
  end

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == '0) |-> !tick); // R4
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !tick); // R5
  AST_TICK_ON_ODD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> pre_en); // R2
  AST_PERIOD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap == tick_ratio(code_q) - RATIO_W'(1))); // R6
  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_code == '0) |=> !tick); // R7
endmodule

bind usec_tick_div usec_tick_div_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_code (cfg_code),
  .tick     (tick),
  .code_q   (code_q),
  .pre_en   (pre_en)
);

// File: tb/usec_tick_div_bench.sv
module usec_tick_div_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_code = 5'd0;
  logic       tick;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  usec_tick_div u_usec_tick_div (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code), .tick(tick)
  );

  always #5 clk = ~clk;

  // bench-side period: odd factor by shift-and-add, then doubled n times
  function automatic int ref_period(input logic [4:0] c);
    int odd;
    int p;
    odd = 1 + 2 * int'(c[1:0]);
    p = odd;
    for (int i = 0; i < int'(c[4:2]); i++) p = p + p;
    return p;
  endfunction

  task automatic report(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write on a falling edge; returns at the sample point of cycle 0
  task automatic write_code(input logic [4:0] c);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_code = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // sample len cycles: tick expected in cycle k when (k+1) % p == 0 (p=0: never)
  task automatic window(input int p, input int len, input string req);
    int bad_k = -1;
    int bad_v = 0;
    for (int k = 0; k < len; k++) begin
      bit exp_t;
      exp_t = (p != 0) && (((k + 1) % p) == 0);
      if (tick !== exp_t && bad_k < 0) begin
        bad_k = k;
        bad_v = int'(tick);
      end
      @(negedge clk);
    end
    if (bad_k >= 0) report(1'b0, req, bad_v, bad_v ^ 1);
    else            report(1'b1, req, 0, 0);
  endtask

  task automatic t_reset();
    int seen = 0;
    for (int k = 0; k < 100; k++) begin
      if (tick !== 1'b0) seen++;
      @(negedge clk);
    end
    report(seen == 0, "R1 idle after reset", seen, 0);
  endtask

  task automatic t_sweep();
    for (int c = 1; c < 32; c++) begin
      int p;
      p = ref_period(5'(c));
      write_code(5'(c));
      window(p, 3 * p, $sformatf("R2 R3 R5 R6 code 0x%02h", c));
    end
  endtask

  task automatic t_restart();
    write_code(5'h1C);
    repeat (50) @(negedge clk);
    write_code(5'h1C);
    window(128, 384, "R5 same-code rewrite");
    write_code(5'h08);
    repeat (2) @(negedge clk);
    write_code(5'h03);
    window(7, 28, "R5 new code mid-period");
  endtask

  task automatic t_zero();
    write_code(5'h09);
    repeat (5) @(negedge clk);
    write_code(5'h00);
    window(0, 2000, "R4 R7 zero code silent");
  endtask

  task automatic t_reset_mid();
    write_code(5'h02);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    window(0, 200, "R1 reset clears code");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_restart();
    t_zero();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule